// File: doc/BRIEF.md
# Asymmetric Three-Slot Decode Allocator

This block sits between an in-order instruction queue and a row of decode slots. Each cycle it looks at up to three entries at the head of the queue and places them into the slots. Slot 0 is a full decoder. The remaining slots are narrow decoders that only accept instructions producing a single micro-op. Every queue entry carries three fields: its micro-op count, a microcode flag and, for microcoded entries, the number of cycles the sequencer needs. The block grants slots, tags each granted slot with a running program-order sequence number, and pops the accepted entries from the queue head. The best steady-state pattern is one wide instruction in slot 0 followed by two single-uop instructions.

The queue side is a valid/ready stream with one lane per head position. `in_valid` must be contiguous from lane 0 (lane k valid means lanes below k are valid too). The block raises `in_ready[k]` only for lanes it accepts, so it always pops a prefix of the head. The queue must keep a lane's fields stable until that lane is accepted. Back-pressure is expressed only by dropping ready. Allocation is strictly in program order. When an entry cannot be placed, that entry and every entry behind it wait for the next cycle.

A granted microcoded entry keeps slot 0 busy for its stated cycle count. During that time no slot is granted. Reset clears any such hold.

Top module: `dslot_alloc`

## Requirements
- R1: After reset, `ucode_busy` is 0, no slot is granted, and the sequence tag of slot 0 is 0.
- R2: When the hold is idle and lane 0 is valid, lane 0 is granted to slot 0, whatever its micro-op count (any value of the 3-bit field) or microcode flag.
- R3: A lane k>0 entry whose micro-op count equals 1 and whose microcode flag is 0 is granted to slot k in the same cycle, provided every lane before it was granted and lane 0 is not microcoded.
- R4: An entry in lane k>0 whose micro-op count is not 1, or whose microcode flag is set, is not granted. Allocation stops there for the cycle, so no later lane is granted even if it is simple.
- R5: Slots 1 and 2 are granted only if slot 0 is granted in the same cycle. The grant vector is always a prefix (lane k granted implies lanes below k granted).
- R6: `in_ready` equals the grant vector and is never raised on an invalid lane. The fields of lanes that are not valid have no effect on any output.
- R7: A granted microcoded lane-0 entry with a cycle count N of 2 or more closes allocation for its own cycle. It then holds `ucode_busy` high with no grants for the next N-1 cycles, after which allocation resumes. A count of 0 or 1 produces no hold.
- R8: Slot k carries the sequence tag S+k modulo 16, where S is the number of entries accepted since reset.
- R9: A reset asserted while a microcode hold is active clears the hold, and the head entry may be granted in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 3 | Per-lane valid of the queue head window (contiguous from lane 0) |
| in_uops | input | 9 | Micro-op count per lane, 3 bits each, lane 0 in the low bits |
| in_ucode | input | 3 | Microcode flag per lane |
| in_ucyc | input | 18 | Microcode cycle count per lane, 6 bits each |
| in_ready | output | 3 | Per-lane accept, the pop of the queue head |
| slot_vld | output | 3 | Slot k holds an instruction this cycle |
| slot_seq | output | 12 | Program-order tag per slot, 4 bits each |
| ucode_busy | output | 1 | Slot 0 is held by a microcoded instruction |

## Verification
The assertions rely on the queue presenting a contiguous valid window and on nothing being offered while reset is low. The stimulus respects this by building each cycle's window as the first n pending entries, where n is the smaller of the backlog and a per-cycle limit. Lanes beyond n carry random junk fields. The instruction stream mixes directed cases with random ones. The directed cases cover the wide-then-two-simple pattern, a wide entry in a later lane, and microcode counts of 0, 1 and long ones. The random cases cover varied counts and flags. A reset is injected in the middle of a long hold.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
  localparam int UOP_W = 3;
  typedef logic [UOP_W-1:0] uop_cnt_t;

  function automatic logic narrow_ok(uop_cnt_t cnt, logic mc);
    return (cnt == UOP_W'(1)) && !mc;
  endfunction
endpackage

// File: rtl/dslot_grant.sv
module dslot_grant
  import dslot_pkg::*;
#(
  parameter int NSLOT = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSLOT-1:0]       lane_vld,
  input  logic [NSLOT*UOP_W-1:0] lane_uops,
  input  logic [NSLOT-1:0]       lane_mc,
  input  logic                   hold,
  output logic [NSLOT-1:0]       grant
);
  genvar k;
  generate
    for (k = 0; k < NSLOT; k++) begin : g_lane
      if (k == 0) begin : g_wide
        assign grant[0] = lane_vld[0] & ~hold;
      end else begin : g_narrow
        assign grant[k] = grant[k-1] & ~lane_mc[k-1] & lane_vld[k]
                        & narrow_ok(lane_uops[k*UOP_W +: UOP_W], lane_mc[k]);

        // R5
        prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
          grant[k] |-> grant[0])
          else $error("narrow slot granted without slot 0");

        // R4
        narrow_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
          grant[k] |-> (lane_uops[k*UOP_W +: UOP_W] == UOP_W'(1)) && !lane_mc[k])
          else $error("wide entry placed in narrow slot");
      end
    end
  endgenerate
endmodule

// File: rtl/dslot_hold.sv
module dslot_hold #(
  parameter int CYCW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CYCW-1:0] len,
  output logic            busy
);
  logic [CYCW-1:0] left_q;

  assign busy = (left_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      left_q <= '0;
    else if (busy)
      left_q <= left_q - CYCW'(1);
    else if (start && len > CYCW'(1))
      left_q <= len - CYCW'(1);
  end

  // R7
  hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len > CYCW'(1)) |=> busy)
    else $error("long microcode did not start a hold");

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start)
    else $error("slot 0 granted while held");
endmodule

// File: rtl/dslot_alloc.sv
module dslot_alloc
  import dslot_pkg::*;
#(
  parameter int NSLOT = 3,
  parameter int CYCW  = 6,
  parameter int SEQW  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSLOT-1:0]       in_valid,
  input  logic [NSLOT*UOP_W-1:0] in_uops,
  input  logic [NSLOT-1:0]       in_ucode,
  input  logic [NSLOT*CYCW-1:0]  in_ucyc,
  output logic [NSLOT-1:0]       in_ready,
  output logic [NSLOT-1:0]       slot_vld,
  output logic [NSLOT*SEQW-1:0]  slot_seq,
  output logic                   ucode_busy
);
  localparam int CNTW = $clog2(NSLOT + 1);

  logic [NSLOT-1:0] grant;
  logic [CNTW-1:0]  taken;
  logic [SEQW-1:0]  seq_q;

  dslot_grant #(.NSLOT(NSLOT)) u_grant (
    .clk      (clk),
    .rst_n    (rst_n),
    .lane_vld (in_valid),
    .lane_uops(in_uops),
    .lane_mc  (in_ucode),
    .hold     (ucode_busy),
    .grant    (grant)
  );

  dslot_hold #(.CYCW(CYCW)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .start(grant[0] & in_ucode[0]),
    .len  (in_ucyc[CYCW-1:0]),
    .busy (ucode_busy)
  );

  always_comb begin
    taken = '0;
    for (int i = 0; i < NSLOT; i++) taken = taken + CNTW'(grant[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) seq_q <= '0;
    else        seq_q <= seq_q + SEQW'(taken);
  end

  assign in_ready = grant;
  assign slot_vld = grant;

  genvar k;
  generate
    for (k = 0; k < NSLOT; k++) begin : g_tag
      assign slot_seq[k*SEQW +: SEQW] = seq_q + SEQW'(k);

      // R6
      ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready[k] |-> in_valid[k])
        else $error("accept on an empty lane");
    end
  endgenerate

  // R7
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ucode_busy |-> (slot_vld == '0))
    else $error("grant during microcode hold");

  // R7
  mc_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld[0] && in_ucode[0]) |-> (slot_vld[NSLOT-1:1] == '0))
    else $error("narrow slot filled beside microcode");

  // R8
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && $past(rst_n) |-> slot_seq[SEQW-1:0] == $past(seq_q + SEQW'(taken)))
    else $error("sequence tag did not advance by accepted count");
endmodule

// File: tb/sim_dslot_alloc.sv
module sim_dslot_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 700;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] in_valid = 0;
  logic [8:0] in_uops = 0;
  logic [2:0] in_ucode = 0;
  logic [17:0] in_ucyc = 0;
  logic [2:0] in_ready, slot_vld;
  logic [11:0] slot_seq;
  logic       ucode_busy;

  int checks = 0, errors = 0, cycles = 0;
  int q_uops[NQ], q_mc[NQ], q_cyc[NQ];
  int tail = 0, head = 0;
  int m_busy = 0, m_seq = 0;
  bit done = 0;

  dslot_alloc u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic add(int u, int mc, int cy);
    q_uops[tail] = u; q_mc[tail] = mc; q_cyc[tail] = cy; tail++;
  endtask

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, got, exp, cycles);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000 && !done) begin
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", cycles, 200000);
        finish_run();
      end
    end
  end

  initial begin
    int nv, lim;
    bit stop, rst_done;
    int eg [3];
    int tag;

    // directed stream
    add(4,0,0); add(1,0,0); add(1,0,0);       // R3 wide then two narrow
    add(1,0,0); add(1,0,0); add(1,0,0);       // all narrow
    add(1,0,0); add(2,0,0); add(1,0,0);       // R4 wide in lane 1
    add(1,0,0); add(1,0,0); add(4,0,0);       // R4 wide in lane 2
    add(3,1,3); add(1,0,0); add(1,0,0);       // R7 N=3
    add(3,1,1); add(1,0,0); add(1,0,0);       // R7 N=1
    add(3,1,0); add(1,0,0);                   // R7 N=0
    add(1,1,2); add(1,0,0);                   // microcode flagged single uop
    add(0,0,0); add(1,0,0); add(7,0,0);       // R2 odd counts
    add(2,1,25); add(1,0,0); add(1,0,0);      // long hold, reset inside (R9)
    while (tail < NQ) begin
      int r = $urandom % 10;
      if (r < 6)      add(1, 0, 0);
      else if (r < 9) add(2 + $urandom % 3, 0, 0);
      else            add($urandom % 8, 1, $urandom % 13);
    end

    // reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", int'(ucode_busy), 0);
    chk("R1", int'(slot_vld), 0);
    chk("R1", int'(slot_seq[3:0]), 0);

    rst_done = 0;
    while (head < tail) begin
      @(negedge clk);
      if (!rst_done && m_busy >= 10) begin
        rst_done = 1;
        rst_n = 0; in_valid = 0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_busy = 0; m_seq = 0;
        #1;
        chk("R9", int'(ucode_busy), 0);
        chk("R9", int'(slot_seq[3:0]), 0);
        continue;
      end
      lim = ((cycles % 7) == 6) ? int'($urandom % 4) : 3;
      nv = (tail - head < lim) ? tail - head : lim;
      in_uops = 9'($urandom); in_ucode = 3'($urandom); in_ucyc = 18'($urandom);
      in_valid = 0;
      for (int k = 0; k < nv; k++) begin
        in_valid[k] = 1;
        in_uops[k*3 +: 3] = 3'(q_uops[head+k]);
        in_ucode[k] = q_mc[head+k][0];
        in_ucyc[k*6 +: 6] = 6'(q_cyc[head+k]);
      end
      #1;
      // reference model
      stop = (m_busy > 0);
      tag = 2;
      for (int k = 0; k < 3; k++) begin
        eg[k] = 0;
        if (!stop && k < nv) begin
          if (k == 0) eg[k] = 1;
          else if (q_uops[head+k] == 1 && q_mc[head+k] == 0) eg[k] = 1;
          else tag = 4;
        end
        if (!eg[k]) stop = 1;
        if (k == 0 && eg[0] && q_mc[head] != 0) stop = 1;
      end
      if (m_busy > 0) tag = 7;
      else if (eg[2]) tag = 3;
      chk(tag == 7 ? "R7" : tag == 3 ? "R3" : tag == 4 ? "R4" : "R2",
          int'(slot_vld), eg[0] + 2*eg[1] + 4*eg[2]);
      chk("R7", int'(ucode_busy), int'(m_busy > 0));
      chk("R6", int'(in_ready), eg[0] + 2*eg[1] + 4*eg[2]);
      chk("R5", int'((slot_vld[1] | slot_vld[2]) & ~slot_vld[0]), 0);
      chk("R8", int'(slot_seq), ((m_seq + 2) % 16) * 256 + ((m_seq + 1) % 16) * 16 + m_seq);
      // state update
      if (m_busy > 0) m_busy--;
      else if (eg[0] && q_mc[head] != 0 && q_cyc[head] > 1) m_busy = q_cyc[head] - 1;
      m_seq = (m_seq + eg[0] + eg[1] + eg[2]) % 16;
      head += eg[0] + eg[1] + eg[2];
    end
    @(negedge clk);
    in_valid = 0;
    done = 1;
    finish_run();
  end
endmodule